// File: doc/BRIEF.md
# Variable-Latency Memory Read Slave

This block sits in the fabric behind a processor's data-side on-chip memory port. The port controller issues a request that lasts one memory-clock cycle. An address-valid pulse marks a read, and the address is good only in that cycle. An enable pulse, which the controller raises for both reads and writes, marks a write when it arrives without address-valid; the write data rides along in the same cycle. The slave captures the request into a holding register and counts down a latency taken from a configuration input. It then raises a one-cycle completion strobe. For a read, the data from its small internal storage array is driven in that same cycle.

Requests may arrive back to back. While one request is in service, one more can wait in a single-entry queue, and it starts its own latency countdown when the active one completes. A request that finds both slots taken is dropped, and a sticky overflow flag is raised. All timing is counted in memory-clock cycles, so the clock ratio of the processor side has no effect on the slave.

Top module: `varlat_slave`

## Requirements
- R1: Synchronous active-high reset clears the active request, the queued request, the countdown, the overflow flag and every storage word to zero, and holds `done`, `rd_data` and `ovf` low.
- R2: A read (request cycle with `req_addr_vld`=1) captured in cycle t with configured latency L (1..15) raises `done` in cycle t+L exactly. In that cycle `rd_data` carries the storage word at `req_addr`, including all writes that completed earlier.
- R3: A configured latency of 0 behaves as latency 1, so completion comes in the cycle after the request.
- R4: A request cycle with `req_en`=1 and `req_addr_vld`=0 is a write. It completes through `done` after the same latency with `rd_data` zero, and from its completion cycle on, the word `req_wdata` is stored at `req_addr`.
- R5: In every cycle with `done` low, `rd_data` is zero.
- R6: A request arriving while another is in service and not completing is queued. It completes L cycles after the completion of the request ahead of it.
- R7: A request arriving in the very cycle the active request completes, with the queue empty, starts at once and completes L cycles later.
- R8: A request arriving while one request is in service (not completing) and another is queued is dropped and never completes. It sets `ovf`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| lat_cfg | input | LAT_W | Latency in cycles, 0 treated as 1 |
| req_en | input | 1 | One-cycle enable pulse, reads and writes |
| req_addr_vld | input | 1 | One-cycle read-address-valid pulse |
| req_addr | input | ADDR_W | Request address, valid in the request cycle |
| req_wdata | input | DATA_W | Write data, valid in the request cycle |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Read data, zero unless a read completes |
| ovf | output | 1 | Sticky flag for a dropped request |

## Verification
The bench uses the defaults: a 4-bit address (16 words), 32-bit data and a 4-bit latency field. The 4-bit latency lets it cover the zero setting, the shortest latency and the largest one of 15 cycles. With only 16 words, random reads often land on addresses that earlier writes changed. Short latencies make the single queue entry fill quickly, so random bursts reach the queued start, the start in the completion cycle and the dropped request often.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic {
        KIND_RD = 1'b0,
        KIND_WR = 1'b1
    } kind_e;

    // Any enable or address-valid pulse opens a request.
    function automatic logic is_req(input logic en, input logic av);
        return en | av;
    endfunction

    // Address-valid marks a read; enable alone marks a write.
    function automatic kind_e kind_of(input logic av);
        return av ? KIND_RD : KIND_WR;
    endfunction

endpackage

// File: rtl/vls_capture.sv
module vls_capture
    import vls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              req_en,
    input  logic              req_addr_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              new_vld,
    output kind_e             new_kind,
    output logic [ADDR_W-1:0] new_addr,
    output logic [DATA_W-1:0] new_wdata
);

    always_comb begin
        new_vld   = is_req(req_en, req_addr_vld);
        new_kind  = kind_of(req_addr_vld);
        new_addr  = req_addr;
        new_wdata = req_wdata;
    end

endmodule

// File: rtl/vls_sched.sv
module vls_sched
    import vls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LAT_W-1:0]  lat_cfg,
    input  logic              new_vld,
    input  kind_e             new_kind,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [DATA_W-1:0] new_wdata,
    output logic              done,
    output kind_e             act_kind,
    output logic [ADDR_W-1:0] act_addr,
    output logic [DATA_W-1:0] act_wdata,
    output logic              ovf
);

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } slot_t;

    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

    slot_t            act_q, que_q, new_slot;
    logic             act_vld, que_vld, ovf_q;
    logic [LAT_W-1:0] rem_q, lat_eff;
    logic             fin;

    always_comb begin
        new_slot.kind  = new_kind;
        new_slot.addr  = new_addr;
        new_slot.wdata = new_wdata;
        lat_eff        = (lat_cfg == '0) ? LAT_ONE : lat_cfg;
        fin            = act_vld && (rem_q == LAT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_vld <= 1'b0;
            que_vld <= 1'b0;
            ovf_q   <= 1'b0;
            rem_q   <= '0;
            act_q   <= '0;
            que_q   <= '0;
        end else if (fin || !act_vld) begin
            if (que_vld) begin
                act_q   <= que_q;
                rem_q   <= lat_eff;
                act_vld <= 1'b1;
                que_vld <= new_vld;
                if (new_vld) que_q <= new_slot;
            end else if (new_vld) begin
                act_q   <= new_slot;
                rem_q   <= lat_eff;
                act_vld <= 1'b1;
            end else begin
                act_vld <= 1'b0;
                rem_q   <= '0;
            end
        end else begin
            rem_q <= rem_q - LAT_ONE;
            if (new_vld) begin
                if (!que_vld) begin
                    que_q   <= new_slot;
                    que_vld <= 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
        end
    end

    assign done      = fin;
    assign act_kind  = act_q.kind;
    assign act_addr  = act_q.addr;
    assign act_wdata = act_q.wdata;
    assign ovf       = ovf_q;

    // R2: countdown steps by one each cycle until completion
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (act_vld && rem_q > LAT_ONE) |=> (act_vld && rem_q == $past(rem_q) - LAT_ONE));

    // R2: an active request never holds a zero countdown
    p_rem_live_r2: assert property (@(posedge clk) disable iff (rst)
        act_vld |-> (rem_q != '0));

    // R6: a queued request always sits behind an active one
    p_queue_behind_r6: assert property (@(posedge clk) disable iff (rst)
        que_vld |-> act_vld);

    // R8: overflow flag is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/vls_store.sv
module vls_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    // R4: a completed write lands in the addressed word
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/varlat_slave.sv
module varlat_slave
    import vls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LAT_W-1:0]  lat_cfg,
    input  logic              req_en,
    input  logic              req_addr_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf
);

    logic              new_vld;
    kind_e             new_kind, act_kind;
    logic [ADDR_W-1:0] new_addr, act_addr;
    logic [DATA_W-1:0] new_wdata, act_wdata, mem_rdata;
    logic              fin, store_we;

    vls_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .req_en       (req_en),
        .req_addr_vld (req_addr_vld),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .new_vld      (new_vld),
        .new_kind     (new_kind),
        .new_addr     (new_addr),
        .new_wdata    (new_wdata)
    );

    vls_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .lat_cfg   (lat_cfg),
        .new_vld   (new_vld),
        .new_kind  (new_kind),
        .new_addr  (new_addr),
        .new_wdata (new_wdata),
        .done      (fin),
        .act_kind  (act_kind),
        .act_addr  (act_addr),
        .act_wdata (act_wdata),
        .ovf       (ovf)
    );

    assign store_we = fin && (act_kind == KIND_WR);

    vls_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .addr  (act_addr),
        .wdata (act_wdata),
        .rdata (mem_rdata)
    );

    assign done    = fin;
    assign rd_data = (fin && act_kind == KIND_RD) ? mem_rdata : '0;

    // R5: data bus stays quiet outside completion cycles
    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (rst)
        !done |-> (rd_data == '0));

endmodule

// File: tb/varlat_slave_bench.sv
module varlat_slave_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  lat_cfg;
    logic        req_en, req_addr_vld;
    logic [3:0]  req_addr;
    logic [31:0] req_wdata;
    logic        done, ovf;
    logic [31:0] rd_data;

    always #5 clk = ~clk;

    varlat_slave u_varlat_slave (
        .clk(clk), .rst(rst), .lat_cfg(lat_cfg),
        .req_en(req_en), .req_addr_vld(req_addr_vld),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .ovf(ovf)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, hd = 0, tl = 0, c_last = 0;
    bit finished = 0, ovf_exp = 0;
    logic [3:0]  e_addr [64];
    bit          e_wr   [64];
    logic [31:0] e_data [64];
    int          e_c    [64];
    string       e_tag  [64];
    logic [31:0] ref_mem [16];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
        end
    endtask

    function automatic int eff_lat(logic [3:0] l);
        return (l == 4'd0) ? 1 : int'(l);
    endfunction

    task automatic step(bit rq, bit wr, logic [3:0] a, logic [31:0] d);
        int idx, n, base;
        @(negedge clk);
        cyc++;
        if (hd != tl && e_c[hd % 64] == cyc) begin
            idx = hd % 64;
            chk(e_tag[idx], 32'(done), 32'd1);
            if (e_wr[idx]) begin
                chk("R4", rd_data, 32'd0);
                ref_mem[e_addr[idx]] = e_data[idx];
            end else begin
                chk("R2", rd_data, ref_mem[e_addr[idx]]);
            end
            hd++;
        end else begin
            chk("R2", 32'(done), 32'd0);
            chk("R5", rd_data, 32'd0);
        end
        chk("R8", 32'(ovf), 32'(ovf_exp));
        req_en       = rq;
        req_addr_vld = rq && !wr;
        req_addr     = a;
        req_wdata    = d;
        if (rq) begin
            n = tl - hd;
            if (n >= 2) begin
                ovf_exp = 1;
            end else begin
                idx  = tl % 64;
                base = (c_last > cyc) ? c_last : cyc;
                e_addr[idx] = a;
                e_wr[idx]   = wr;
                e_data[idx] = d;
                e_c[idx]    = base + eff_lat(lat_cfg);
                if (lat_cfg == 4'd0)                e_tag[idx] = "R3";
                else if (n == 1)                    e_tag[idx] = "R6";
                else if (c_last == cyc && cyc > 0)  e_tag[idx] = "R7";
                else                                e_tag[idx] = "R2";
                c_last = e_c[idx];
                tl++;
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 4'd0, 32'd0);
    endtask

    task automatic drain();
        while (hd != tl) idle();
        idle();
    endtask

    task automatic do_reset();
        rst = 1; req_en = 0; req_addr_vld = 0; req_addr = 0; req_wdata = 0;
        repeat (3) @(negedge clk);
        chk("R1", 32'(done), 32'd0);
        chk("R1", rd_data, 32'd0);
        chk("R1", 32'(ovf), 32'd0);
        rst = 0;
        cyc = 0; hd = 0; tl = 0; c_last = 0; ovf_exp = 0;
        for (int i = 0; i < 16; i++) ref_mem[i] = 32'd0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        lat_cfg = 4'd1;
        do_reset();
        // R1: storage cleared by reset
        step(1, 0, 4'd9, 0); drain();
        // R2 / R4 at latency 1
        step(1, 1, 4'd2, 32'hA5A5_0001); drain();
        step(1, 0, 4'd2, 0); drain();
        // R3: zero latency acts as one
        lat_cfg = 4'd0;
        step(1, 0, 4'd2, 0); step(1, 1, 4'd5, 32'h1234_5678); drain();
        step(1, 0, 4'd5, 0); drain();
        // R2: largest latency
        lat_cfg = 4'd15;
        step(1, 0, 4'd5, 0); drain();
        // R6 / R8: burst beyond queue depth
        lat_cfg = 4'd3;
        for (int i = 0; i < 6; i++) step(1, i[0], 4'(i), 32'hC0DE_0000 + i);
        drain();
        // R7: new request in completion cycle
        lat_cfg = 4'd2;
        step(1, 0, 4'd1, 0); idle(); step(1, 0, 4'd0, 0); drain();
        // random phases
        for (int s = 0; s < 40; s++) begin
            lat_cfg = 4'($urandom_range(0, 15));
            for (int k = 0; k < 60; k++) begin
                bit r = ($urandom_range(0, 2) == 0);
                step(r, ($urandom_range(0, 9) < 3), 4'($urandom), $urandom);
            end
            drain();
        end
        // R1 / R8: reset clears sticky overflow and storage
        do_reset();
        lat_cfg = 4'd1;
        step(1, 0, 4'd2, 0); drain();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule